// File: doc/BRIEF.md
# GPIO Pin Interrupt Sense Unit

This block qualifies raw pin levels for a general-purpose I/O port and turns them into interrupt requests. Every pin has its own configuration: output or input direction, an input enable, and three bits that pick the sense mode. With the edge bit clear the pin is level sensitive, active-high or active-low. With the edge bit set it detects a rising edge, a falling edge or both edges. All pins are evaluated in parallel on every clock.

The owning register file keeps the port data register. It feeds the register's current value in on `data_i` and writes `data_o` back each clock. An accepted input pin overwrites its data bit with the sampled level. The bit that is still stored is the old level used for edge detection. Each pin's result is held in an interrupt-state vector. Two independent masks reduce that vector to two request lines, A and B. An optional synchroniser (`SYNC_STAGES`, default 2) sits in front of the pins when they are asynchronous. All ports are plain control and status signals, with no handshake.

Top module: `gpio_irq_sense`

## Requirements
- R1: While `rst_n` is low and on leaving reset, `irq_state_o` is zero and both `irq_a_o` and `irq_b_o` are low.
- R2: A pin whose `dir_i` bit is 1, or whose `inen_i` bit is 0, is ignored. Its `data_o` bit equals its `data_i` bit. A level-mode pin keeps its interrupt-state bit unchanged.
- R3: For an accepted pin (`dir_i`=0, `inen_i`=1), the `data_o` bit equals the synchronised pin level.
- R4: Level mode (`edge_i`=0): the state bit is set while the level differs from the `polar_i` bit and clear while it equals it. `polar_i`=0 means active-high and `polar_i`=1 means active-low.
- R5: Single-edge mode (`edge_i`=1, `both_i`=0): `polar_i`=0 detects only a 0-to-1 change of the data bit, and `polar_i`=1 detects only a 1-to-0 change.
- R6: Both-edge mode (`edge_i`=1, `both_i`=1): any change of the data bit is detected.
- R7: An edge detection sets the state bit for exactly one clock cycle, visible on the masked outputs. An edge-mode pin that is not accepted has its state bit cleared.
- R8: `irq_a_o` is 1 exactly when `irq_state_o & mask_a_i` is nonzero, and `irq_b_o` is the same with `mask_b_i`. A mask change takes effect in the same cycle, with no clock edge.
- R9: With `SYNC_STAGES`=2, a pin change appears on `data_o` after exactly two rising clock edges. The state bit follows one edge later.
- R10: All pins are sensed independently and at the same time. A pattern applied to many pins at once shows up in full in `data_o` and `irq_state_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | PINS | Raw pin levels |
| dir_i | input | PINS | 1 = pin is an output (input ignored) |
| inen_i | input | PINS | 1 = input buffer enabled |
| polar_i | input | PINS | Level: 1 = active-low; edge: 1 = falling |
| edge_i | input | PINS | 1 = edge sensitive, 0 = level sensitive |
| both_i | input | PINS | 1 = both edges when edge sensitive |
| mask_a_i | input | PINS | Enable mask for request A |
| mask_b_i | input | PINS | Enable mask for request B |
| data_i | input | PINS | Current data register value |
| data_o | output | PINS | Updated data register value |
| irq_state_o | output | PINS | Per-pin interrupt state |
| irq_a_o | output | 1 | Interrupt request A |
| irq_b_o | output | 1 | Interrupt request B |

## Verification
The bench keeps the data register itself and feeds `data_o` back to `data_i`, so edge pulses appear with the real timing.

- **Wrong synchroniser depth:** the bench samples `data_o` one edge early and one edge on time. A design with a different depth fails one of the two.
- **Wrong edge polarity:** the bench drives the opposite transition on rise-only and fall-only pins. A design that mixes up the polarity raises an interrupt where none belongs.
- **Pulse length:** the bench checks that an edge pulse is gone one cycle later. A design that holds the pulse, or re-fires it because the data register was not updated, fails that check.
- **Disabled pins:** the bench toggles output pins and input-disabled pins and expects no data or state change.
- **Registered mask:** the bench changes a mask between clock edges. A design that registers the mask output shows the change one cycle late.

// File: rtl/gpio_sense_pkg.sv
package gpio_sense_pkg;

  localparam int unsigned GPIO_PINS = 16;

  typedef enum logic [2:0] {
    SENSE_LVL_HI = 3'd0,
    SENSE_LVL_LO = 3'd1,
    SENSE_RISE   = 3'd2,
    SENSE_FALL   = 3'd3,
    SENSE_ANY    = 3'd4
  } sense_mode_e;

  // Collapse the three per-pin configuration bits into one mode.
  function automatic sense_mode_e sense_decode(logic edge_b, logic both_b, logic polar_b);
    if (!edge_b)     return polar_b ? SENSE_LVL_LO : SENSE_LVL_HI;
    else if (both_b) return SENSE_ANY;
    else             return polar_b ? SENSE_FALL : SENSE_RISE;
  endfunction

  // Next state bit for an accepted pin, given old and new level.
  function automatic logic sense_eval(sense_mode_e mode, logic old_b, logic new_b);
    case (mode)
      SENSE_LVL_HI: return new_b;
      SENSE_LVL_LO: return ~new_b;
      SENSE_RISE:   return ~old_b & new_b;
      SENSE_FALL:   return old_b & ~new_b;
      SENSE_ANY:    return old_b ^ new_b;
      default:      return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] sync_o
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign sync_o = raw_i;
    end else begin : g_chain
      logic [W-1:0] stage_q [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
          stage_q[0] <= raw_i;
          for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
      end

      assign sync_o = stage_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/gpio_sense_core.sv
module gpio_sense_core
  import gpio_sense_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] inen_i,
  input  logic [W-1:0] polar_i,
  input  logic [W-1:0] edge_i,
  input  logic [W-1:0] both_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] data_o,
  output logic [W-1:0] state_o
);

  generate
    for (genvar p = 0; p < W; p++) begin : g_pin
      sense_mode_e mode;
      logic        accept;
      logic        st_q;

      assign mode   = sense_decode(edge_i[p], both_i[p], polar_i[p]);
      assign accept = ~dir_i[p] & inen_i[p];

      // The stored data bit is the old level; the sampled pin is the new one.
      assign data_o[p] = accept ? lvl_i[p] : data_i[p];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_q <= 1'b0;
        end else if (accept) begin
          st_q <= sense_eval(mode, data_i[p], lvl_i[p]);
        end else if (edge_i[p]) begin
          st_q <= 1'b0;
        end
      end

      assign state_o[p] = st_q;
    end
  endgenerate

endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] state_i,
  input  logic [W-1:0] mask_a_i,
  input  logic [W-1:0] mask_b_i,
  output logic         irq_a_o,
  output logic         irq_b_o
);

  // Left combinational so a mask write is seen without a clock edge.
  assign irq_a_o = |(state_i & mask_a_i);
  assign irq_b_o = |(state_i & mask_b_i);

endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense
  import gpio_sense_pkg::*;
#(
  parameter int unsigned PINS        = GPIO_PINS,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_i,
  input  logic [PINS-1:0] dir_i,
  input  logic [PINS-1:0] inen_i,
  input  logic [PINS-1:0] polar_i,
  input  logic [PINS-1:0] edge_i,
  input  logic [PINS-1:0] both_i,
  input  logic [PINS-1:0] mask_a_i,
  input  logic [PINS-1:0] mask_b_i,
  input  logic [PINS-1:0] data_i,
  output logic [PINS-1:0] data_o,
  output logic [PINS-1:0] irq_state_o,
  output logic            irq_a_o,
  output logic            irq_b_o
);

  logic [PINS-1:0] lvl_sync;

  gpio_pin_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (pin_i),
    .sync_o (lvl_sync)
  );

  gpio_sense_core #(.W(PINS)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl_i   (lvl_sync),
    .dir_i   (dir_i),
    .inen_i  (inen_i),
    .polar_i (polar_i),
    .edge_i  (edge_i),
    .both_i  (both_i),
    .data_i  (data_i),
    .data_o  (data_o),
    .state_o (irq_state_o)
  );

  gpio_irq_merge #(.W(PINS)) u_merge (
    .state_i  (irq_state_o),
    .mask_a_i (mask_a_i),
    .mask_b_i (mask_b_i),
    .irq_a_o  (irq_a_o),
    .irq_b_o  (irq_b_o)
  );

endmodule

// File: rtl/gpio_irq_sense_chk.sv
module gpio_irq_sense_chk #(
  parameter int unsigned PINS = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PINS-1:0] dir_i,
  input logic [PINS-1:0] inen_i,
  input logic [PINS-1:0] polar_i,
  input logic [PINS-1:0] edge_i,
  input logic [PINS-1:0] mask_a_i,
  input logic [PINS-1:0] mask_b_i,
  input logic [PINS-1:0] data_i,
  input logic [PINS-1:0] data_o,
  input logic [PINS-1:0] irq_state_o,
  input logic            irq_a_o,
  input logic            irq_b_o
);

  logic [PINS-1:0] acc;
  assign acc = ~dir_i & inen_i;

  // R8
  irq_a_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_a_o == ((irq_state_o & mask_a_i) != '0));

  // R8
  irq_b_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_b_o == ((irq_state_o & mask_b_i) != '0));

  // R2
  ignored_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_o ^ data_i) & ~acc) == '0);

  // R2
  ignored_state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_state_o ^ $past(irq_state_o)) & ~$past(acc) & ~$past(edge_i)) == '0);

  // R4
  level_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_state_o ^ $past(data_o ^ polar_i)) & $past(acc & ~edge_i)) == '0);

  // R7
  edge_idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_state_o & $past(edge_i & ~acc)) == '0);

endmodule

bind gpio_irq_sense gpio_irq_sense_chk #(.PINS(PINS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dir_i       (dir_i),
  .inen_i      (inen_i),
  .polar_i     (polar_i),
  .edge_i      (edge_i),
  .mask_a_i    (mask_a_i),
  .mask_b_i    (mask_b_i),
  .data_i      (data_i),
  .data_o      (data_o),
  .irq_state_o (irq_state_o),
  .irq_a_o     (irq_a_o),
  .irq_b_o     (irq_b_o)
);

// File: tb/gpio_irq_sense_bench.sv
`timescale 1ns/1ps
module gpio_irq_sense_bench;

  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin = '0, dir = '0, inen = '0, polar = '0, edg = '0, both = '0;
  logic [N-1:0] mask_a = '0, mask_b = '0;
  logic [N-1:0] data_reg;
  logic [N-1:0] data_o, irq_state;
  logic         irq_a, irq_b;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  // Data register owned by the surrounding register file.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_reg <= '0;
    else        data_reg <= data_o;
  end

  gpio_irq_sense u_gpio_irq_sense (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_i       (pin),
    .dir_i       (dir),
    .inen_i      (inen),
    .polar_i     (polar),
    .edge_i      (edg),
    .both_i      (both),
    .mask_a_i    (mask_a),
    .mask_b_i    (mask_b),
    .data_i      (data_reg),
    .data_o      (data_o),
    .irq_state_o (irq_state),
    .irq_a_o     (irq_a),
    .irq_b_o     (irq_b)
  );

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic quiesce();
    pin = '0; dir = '0; edg = '0; both = '0; polar = '0;
    inen = '1; mask_a = '1; mask_b = '0;
    step(5);
  endtask

  task automatic t_reset();
    step(2);
    chk("R1 state in reset", irq_state, 0);
    chk("R1 irq_a in reset", irq_a, 0);
    rst_n = 1'b1;
    step(1);
    chk("R1 state after reset", irq_state, 0);
    chk("R1 irq_b after reset", irq_b, 0);
  endtask

  task automatic t_level();
    quiesce();
    inen = 16'h0003; polar = 16'h0002;
    step(2);
    chk("R4 active-low idle", irq_state, 16'h0002);
    pin[0] = 1'b1;
    step(1);
    chk("R9 one edge not yet", data_o[0], 0);
    step(1);
    chk("R9 R3 data after two edges", data_o[0], 1);
    step(1);
    chk("R4 active-high set", irq_state, 16'h0003);
    chk("R8 irq_a", irq_a, 1);
    step(3);
    chk("R4 level held", irq_state, 16'h0003);
    pin[1] = 1'b1;
    step(3);
    chk("R4 active-low release", irq_state, 16'h0001);
    pin[0] = 1'b0;
    step(3);
    chk("R4 active-high release", irq_state, 16'h0000);
  endtask

  task automatic t_ignore();
    quiesce();
    dir = 16'h0004; inen = 16'hFFF7;
    step(2);
    pin[3:2] = 2'b11;
    step(4);
    chk("R2 data of ignored pins", data_o[3:2], 0);
    chk("R2 state of ignored pins", irq_state[3:2], 0);
    pin[4] = 1'b1;
    step(3);
    chk("R2 setup level pin", irq_state[4], 1);
    dir[4] = 1'b1;
    pin[4] = 1'b0;
    step(4);
    chk("R2 state held when ignored", irq_state[4], 1);
    chk("R2 data held when ignored", data_o[4], 1);
    dir = '0; pin = '0;
    step(4);
  endtask

  task automatic t_edge();
    quiesce();
    edg = 16'h0003; polar = 16'h0002;
    step(4);
    chk("R5 no spurious pulse", irq_state, 0);
    pin[0] = 1'b1;
    step(3);
    chk("R5 rise detected", irq_state, 16'h0001);
    chk("R7 pulse on irq_a", irq_a, 1);
    step(1);
    chk("R7 pulse is one cycle", irq_state, 0);
    pin[0] = 1'b0;
    step(3);
    chk("R5 fall ignored on rise pin", irq_state, 0);
    step(1);
    chk("R5 fall ignored later", irq_state, 0);
    pin[1] = 1'b1;
    step(3);
    chk("R5 rise ignored on fall pin", irq_state, 0);
    pin[1] = 1'b0;
    step(3);
    chk("R5 fall detected", irq_state, 16'h0002);
    step(1);
    chk("R7 fall pulse ends", irq_state, 0);
  endtask

  task automatic t_both();
    quiesce();
    edg = 16'h0001; both = 16'h0001;
    step(4);
    pin[0] = 1'b1;
    step(3);
    chk("R6 rise detected", irq_state, 16'h0001);
    step(1);
    chk("R6 R7 pulse ends", irq_state, 0);
    pin[0] = 1'b0;
    step(3);
    chk("R6 fall detected", irq_state, 16'h0001);
    step(1);
    chk("R6 R7 pulse ends after fall", irq_state, 0);
  endtask

  task automatic t_mask();
    quiesce();
    mask_a = 16'h0001;
    pin = 16'h0021;
    step(4);
    chk("R8 irq_a masked in", irq_a, 1);
    chk("R8 irq_b masked out", irq_b, 0);
    mask_b = 16'h0020;
    #1;
    chk("R8 irq_b same cycle", irq_b, 1);
    mask_a = 16'h0000;
    #1;
    chk("R8 irq_a dropped same cycle", irq_a, 0);
    mask_b = 16'h0002;
    #1;
    chk("R8 irq_b on idle pin", irq_b, 0);
  endtask

  task automatic t_parallel();
    quiesce();
    pin = 16'hA5A5;
    step(3);
    chk("R10 data pattern", data_o, 16'hA5A5);
    chk("R10 state pattern", irq_state, 16'hA5A5);
    pin = 16'h5A5A;
    step(3);
    chk("R10 inverted pattern", irq_state, 16'h5A5A);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_level();
    t_ignore();
    t_edge();
    t_both();
    t_mask();
    t_parallel();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule